// File: doc/BRIEF.md
# Programmable Pin Input Debounce Filter

This block cleans up one general-purpose input pin before the rest of the chip sees it. The raw pin first passes through a two-flop synchronizer. A filter then decides when the clean output level may follow the synchronized level. Filter time is measured in pulses of a slow real-time tick enable (`tick_en`). A prescaler groups those pulses into timebase units of 2, 8, 512 or 2048 pulses. A 4-bit count sets how many units a new level must hold.

Four filter behaviours are selectable:

- Pass-through.
- Symmetric glitch removal, where both edges are debounced.
- Keep-low-pulses, where a falling level passes at once and only a rising level is debounced.
- Keep-high-pulses, the mirror of keep-low-pulses.

Any change to the configuration inputs restarts the filter. It also reloads the output from the synchronized pin in that same cycle.

Top module: `pin_debounce_filter`

## Requirements
- R1: In pass-through, a new `pin_in` level appears on `level_out` at the third rising `clk` edge after it is applied, and not before.
- R2: While `rst_n` is low and after it is released, `level_out` is 0 until the pin level propagates.
- R3: The filter is bypassed, with the R1 timing, when `filt_mode` is 2'b00 or `tmr_count` is 0.
- R4: `{tb_large,tb_unit}` sets the unit: 2'b00 is 2, 2'b01 is 8, 2'b10 is 512 and 2'b11 is 2048 `tick_en` pulses. The filter length L is `tmr_count` times the unit.
- R5: With `filt_mode` 2'b01, a level that is applied before rising edge N and held reaches `level_out` at edge N+1+L. The pass-through case is the same formula with L=1.
- R6: In a debounced direction, a return of the synchronized input to the output level clears the accumulated time. A later change needs the full L again.
- R7: With `filt_mode` 2'b10, a falling level passes with the R1 timing and a rising level is debounced as in R5. A low pulse is therefore kept, and the return to high is delayed by L.
- R8: With `filt_mode` 2'b11, a rising level passes with the R1 timing and a falling level is debounced as in R5.
- R9: Clock cycles without `tick_en` add no filter time. The output holds while `tick_en` is low.
- R10: A change of any configuration input clears the filter time. It also loads `level_out` from the synchronized input at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Real-time tick enable, one pulse per tick |
| pin_in | input | 1 | Raw, asynchronous pin level |
| tmr_count | input | CNT_W | Number of timebase units in the filter length |
| tb_large | input | 1 | Timebase select, upper bit |
| tb_unit | input | 1 | Timebase select, lower bit |
| filt_mode | input | 2 | 00 pass, 01 remove both, 10 keep low pulses, 11 keep high pulses |
| level_out | output | 1 | Filtered pin level |

## Verification
The bench measures the exact edge at which each change lands, for every timebase and for the shortest setting. An off-by-one in the prescaler or the unit counter would move the output one cycle early or late. A bounce shorter than L, followed at once by a held change, catches a counter that is not cleared: the output would flip before the full time. Short pulses in both keep modes expose a swapped polarity, which would delay the kept edge or pass the filtered one. A change of configuration in the middle of a long count must reload the output at once. Stretches without `tick_en` must freeze the filter; a design that counts clocks instead would finish early.

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
  parameter int CNT_W = 4,
  parameter int UNIT0 = 2,
  parameter int UNIT1 = 8,
  parameter int UNIT2 = 512,
  parameter int UNIT3 = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             pin_in,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             tb_large,
  input  logic             tb_unit,
  input  logic [1:0]       filt_mode,
  output logic             level_out
);
  localparam int PRE_W = $clog2(UNIT3);
  localparam int CFG_W = CNT_W + 4;

  logic             s1_q, s2_q, out_q;
  logic [PRE_W-1:0] pre_q, unit_last;
  logic [CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_chg, filt_on, differ, fast_pass, last_unit;

  always_comb begin
    case ({tb_large, tb_unit})
      2'b00:   unit_last = PRE_W'(UNIT0 - 1);
      2'b01:   unit_last = PRE_W'(UNIT1 - 1);
      2'b10:   unit_last = PRE_W'(UNIT2 - 1);
      default: unit_last = PRE_W'(UNIT3 - 1);
    endcase
  end

  assign cfg_d     = {filt_mode, tb_large, tb_unit, tmr_count};
  assign cfg_chg   = cfg_d != cfg_q;
  assign filt_on   = (filt_mode != 2'b00) && (tmr_count != '0);
  assign differ    = s2_q != out_q;
  assign fast_pass = (filt_mode == 2'b10 && !s2_q) || (filt_mode == 2'b11 && s2_q);
  assign last_unit = cnt_q == tmr_count - 1'b1;
  assign level_out = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      out_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      cfg_q <= cfg_d;
      if (cfg_chg || !filt_on || !differ || fast_pass) begin
        out_q <= s2_q;
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick_en) begin
        if (pre_q == unit_last) begin
          pre_q <= '0;
          if (last_unit) begin
            out_q <= s2_q;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  a_r3_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!filt_on) |-> level_out == $past(s2_q));

  a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_on && !cfg_chg && filt_mode == 2'b01) && !$stable(level_out)) |-> $past(tick_en));

  a_r6_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s2_q == out_q) |-> cnt_q == '0);

  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_on && !cfg_chg && filt_mode == 2'b10) && $rose(level_out)) |-> $past(tick_en));

  a_r8_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_on && !cfg_chg && filt_mode == 2'b11) && $fell(level_out)) |-> $past(tick_en));

  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_chg) |-> (level_out == $past(s2_q) && cnt_q == '0));
endmodule

// File: tb/pin_debounce_filter_tb_top.sv
module pin_debounce_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       pin_in = 1'b0;
  logic [3:0] tmr_count = 4'd0;
  logic       tb_large = 1'b0;
  logic       tb_unit = 1'b0;
  logic [1:0] filt_mode = 2'b00;
  logic       level_out;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    cur = 1'b0;
  int    qc[$];
  bit    qv[$];
  string qt[$];

  pin_debounce_filter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pin_in(pin_in),
    .tmr_count(tmr_count), .tb_large(tb_large), .tb_unit(tb_unit),
    .filt_mode(filt_mode), .level_out(level_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!done) begin
      while (qc.size() > 0 && qc[0] <= cyc) begin
        checks++;
        if (qc[0] < cyc) begin
          failures++;
          $display("FAIL %s missed cycle %0d actual=none expected=%0b", qt[0], qc[0], qv[0]);
        end else if (level_out !== qv[0]) begin
          failures++;
          $display("FAIL %s cycle %0d actual=%0b expected=%0b", qt[0], cyc, level_out, qv[0]);
        end
        void'(qc.pop_front());
        void'(qv.pop_front());
        void'(qt.pop_front());
      end
      if (cyc > 120000) begin
        checks++;
        failures++;
        $display("FAIL watchdog cycle %0d actual=running expected=finished", cyc);
        finish_run();
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int c, bit v, string t);
    qc.push_back(c);
    qv.push_back(v);
    qt.push_back(t);
  endtask

  task automatic flip(bit v, int len, string t);
    bit old;
    old = cur;
    pin_in = v;
    expect_at(cyc + 1 + len, old, t);
    expect_at(cyc + 2 + len, v, t);
    cur = v;
    step(len + 4);
  endtask

  task automatic set_cfg(logic [1:0] m, bit lg, bit un, logic [3:0] n);
    filt_mode = m;
    tb_large = lg;
    tb_unit = un;
    tmr_count = n;
    step(4);
  endtask

  initial begin
    int c;
    step(2);
    expect_at(cyc + 1, 1'b0, "R2 in reset");
    step(2);
    rst_n = 1'b1;
    expect_at(cyc + 2, 1'b0, "R2 after release");
    step(4);

    flip(1'b1, 1, "R1 pass rise");
    flip(1'b0, 1, "R3 mode 00 fall");
    set_cfg(2'b01, 1'b0, 1'b0, 4'd0);
    flip(1'b1, 1, "R3 count 0");

    set_cfg(2'b01, 1'b0, 1'b0, 4'd3);
    flip(1'b0, 6, "R5 remove fall");
    flip(1'b1, 6, "R5 remove rise");
    set_cfg(2'b01, 1'b0, 1'b0, 4'd1);
    flip(1'b0, 2, "R4 minimum setting");
    set_cfg(2'b01, 1'b0, 1'b1, 4'd2);
    flip(1'b1, 16, "R4 unit 8");
    set_cfg(2'b01, 1'b1, 1'b0, 4'd3);
    flip(1'b0, 1536, "R4 unit 512");
    set_cfg(2'b01, 1'b1, 1'b1, 4'd1);
    flip(1'b1, 2048, "R4 unit 2048");

    set_cfg(2'b01, 1'b0, 1'b0, 4'd3);
    c = cyc;
    pin_in = 1'b0;
    expect_at(c + 8, 1'b1, "R6 bounce held off");
    step(4);
    pin_in = 1'b1;
    step(2);
    pin_in = 1'b0;
    expect_at(c + 10, 1'b1, "R6 restart early");
    expect_at(c + 13, 1'b1, "R6 restart full");
    expect_at(c + 14, 1'b0, "R6 restart done");
    cur = 1'b0;
    step(12);

    set_cfg(2'b10, 1'b0, 1'b0, 4'd3);
    flip(1'b1, 6, "R7 rise debounced");
    flip(1'b0, 1, "R7 fall immediate");
    flip(1'b1, 6, "R7 rise again");
    c = cyc;
    pin_in = 1'b0;
    expect_at(c + 2, 1'b1, "R7 pulse before");
    expect_at(c + 3, 1'b0, "R7 low pulse kept");
    step(2);
    pin_in = 1'b1;
    expect_at(c + 9, 1'b0, "R7 return held");
    expect_at(c + 10, 1'b1, "R7 return debounced");
    cur = 1'b1;
    step(12);

    set_cfg(2'b11, 1'b0, 1'b0, 4'd3);
    flip(1'b0, 6, "R8 fall debounced");
    flip(1'b1, 1, "R8 rise immediate");

    set_cfg(2'b01, 1'b0, 1'b0, 4'd1);
    tick_en = 1'b0;
    c = cyc;
    pin_in = 1'b0;
    expect_at(c + 40, 1'b1, "R9 frozen without tick");
    step(50);
    c = cyc;
    tick_en = 1'b1;
    expect_at(c + 1, 1'b1, "R9 resume before");
    expect_at(c + 2, 1'b0, "R9 resume done");
    cur = 1'b0;
    step(6);

    set_cfg(2'b01, 1'b1, 1'b1, 4'd15);
    c = cyc;
    pin_in = 1'b1;
    expect_at(c + 19, 1'b0, "R10 counting");
    step(20);
    c = cyc;
    tmr_count = 4'd14;
    expect_at(c + 1, 1'b1, "R10 reload on change");
    cur = 1'b1;
    step(5);
    flip(1'b0, 14 * 2048, "R10 restarted length");

    step(5);
    if (qc.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", qc.size());
    end
    finish_run();
  end
endmodule